// File: doc/BRIEF.md
# Floating-Point Exception Trap and Default-Result Unit

This block sits at the output of a single-precision floating-point datapath. It owns the 32-bit FPU control register, which holds six per-exception enable bits and the rounding mode. Each cycle in which the datapath presents a finished operation, the block looks at the raw exception flags that came with it. If any of those exceptions is enabled, it raises a one-cycle trap request, names the cause and suppresses the destination write. Otherwise it writes the result, replacing it with the standard substitute value where a disabled exception requires one.

The substitute depends on the exception, the instruction class (arithmetic, conversion or compare), the result sign and the rounding mode. An invalid compare does not change the data word. Instead it sets the unordered bit of the condition code. The arithmetic datapath and the trap handler are outside this block.

Top module: `fpu_exc_gate`

## Requirements
- R1: The control register is read and written as a whole 32-bit word. A write on `csr_we_i` takes effect at the clock edge and is visible on `csr_rdata_o` from the next cycle. Bits 17 down to 12 are the enables in the order denormal, inexact, underflow, overflow, divide-by-zero, invalid, and bits 1:0 are the rounding mode.
- R2: Reset clears the control register, so all enables start at 0. The trap request, the cause, the write strobe, the data and the condition code are all 0 after reset.
- R3: When `op_valid_i` is high and at least one flagged exception is enabled, `trap_o` is high for exactly the following cycle and `wr_valid_o` stays low in that cycle. The flag vector `op_flags_i` uses bit 5 = denormal, 4 = inexact, 3 = underflow, 2 = overflow, 1 = divide-by-zero, 0 = invalid.
- R4: When several enabled exceptions fire at once, `trap_cause_o` is one-hot and selects the first of invalid, divide-by-zero, denormal, overflow, underflow, inexact, using the same bit positions as `op_flags_i`.
- R5: A disabled denormal-input flag raises no trap and leaves the result word unchanged.
- R6: A disabled inexact flag writes the rounded result unchanged.
- R7: A disabled underflow writes a zero carrying the result sign.
- R8: A disabled overflow writes a value chosen by the rounding mode (00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf). Nearest gives ±infinity (7F800000 with the sign in bit 31) and toward zero gives ±MAX (7F7FFFFF with the sign). Toward +inf gives +infinity for a positive result and -MAX for a negative one. Toward -inf gives -infinity for a negative result and +MAX for a positive one.
- R9: A disabled divide-by-zero writes infinity with the result sign.
- R10: A disabled invalid operation depends on `op_class_i` (00 arithmetic, 01 conversion, 10 compare). Arithmetic writes the quiet NaN 7FC00000. Conversion writes ±MAX. Compare passes the data word and sets bit 0 (unordered) of the condition code.
- R11: With several flags set and none enabled, the substitute is chosen in the order invalid, divide-by-zero, overflow, underflow.
- R12: In a cycle with `op_valid_i` low, the following cycle has no trap and no write, and the data and condition-code outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_we_i | input | 1 | Control register write strobe |
| csr_wdata_i | input | 32 | Control register write data |
| csr_rdata_o | output | 32 | Control register contents |
| op_valid_i | input | 1 | Datapath result valid |
| op_flags_i | input | 6 | Raw exception flags (D,X,U,O,Z,V at 5..0) |
| op_class_i | input | 2 | Instruction class |
| op_sign_i | input | 1 | Sign of the exact result |
| op_result_i | input | 32 | Rounded result word |
| op_cc_i | input | 4 | Condition code from the datapath |
| trap_o | output | 1 | One-cycle trap request |
| trap_cause_o | output | 6 | One-hot trapping exception |
| wr_valid_o | output | 1 | Destination write strobe |
| wr_data_o | output | 32 | Value written to the destination |
| wr_cc_o | output | 4 | Condition code written |

## Verification
The assertions take for granted that the datapath never presents class code 11 with a valid result. They also assume the flags and class are meaningful only while `op_valid_i` is high. The bench therefore draws the class only from the three defined codes, and in idle cycles it leaves flags and data at arbitrary values to show they are ignored. The assertions also assume that no control-register write lands in the same cycle as a checked operation. When the bench mixes writes and operations at random, its model applies each operation against the enables as they stood before that cycle's write.

// File: rtl/fpu_exc_pkg.sv
package fpu_exc_pkg;

  localparam int DATA_W = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = DATA_W - 1 - EXP_W;
  localparam int FLAG_W = 6;

  // Flag index: same position in the flag vector and the enable field
  localparam int F_INV = 0;
  localparam int F_DZ  = 1;
  localparam int F_OVF = 2;
  localparam int F_UNF = 3;
  localparam int F_INX = 4;
  localparam int F_DEN = 5;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'b00,
    CLS_CONV  = 2'b01,
    CLS_CMP   = 2'b10
  } op_class_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_MINF = 2'b11
  } rmode_e;

  function automatic logic [DATA_W-1:0] fp_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] fp_max(input logic s);
    return {s, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
  endfunction

  function automatic logic [DATA_W-1:0] fp_qnan();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] fp_zero(input logic s);
    return {s, {(DATA_W-1){1'b0}}};
  endfunction

  // Masked overflow: infinity or largest finite value by rounding direction
  function automatic logic [DATA_W-1:0] fp_ovf_default(input logic s, input rmode_e rm);
    logic to_inf;
    case (rm)
      RM_NEAR: to_inf = 1'b1;
      RM_ZERO: to_inf = 1'b0;
      RM_PINF: to_inf = ~s;
      default: to_inf = s;
    endcase
    return to_inf ? fp_inf(s) : fp_max(s);
  endfunction

endpackage

// File: rtl/fpu_exc_csr.sv
module fpu_exc_csr
  import fpu_exc_pkg::*;
#(
  parameter int CSR_W   = 32,
  parameter int ENA_LSB = 12,
  parameter int RM_LSB  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CSR_W-1:0]  wdata_i,
  output logic [CSR_W-1:0]  csr_o,
  output logic [FLAG_W-1:0] enables_o,
  output rmode_e            rmode_o
);

  logic [CSR_W-1:0] csr_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   csr_q <= '0;
    else if (we_i) csr_q <= wdata_i;
  end

  assign csr_o     = csr_q;
  assign enables_o = csr_q[ENA_LSB +: FLAG_W];
  assign rmode_o   = rmode_e'(csr_q[RM_LSB +: 2]);

endmodule

// File: rtl/fpu_exc_trap_sel.sv
module fpu_exc_trap_sel
  import fpu_exc_pkg::*;
(
  input  logic              valid_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] enables_i,
  output logic              fire_o,
  output logic [FLAG_W-1:0] cause_o
);

  // Trap priority: invalid, divide-by-zero, denormal, overflow, underflow, inexact
  localparam int PRIO [FLAG_W] = '{F_INV, F_DZ, F_DEN, F_OVF, F_UNF, F_INX};

  logic [FLAG_W-1:0] hits;
  assign hits   = valid_i ? (flags_i & enables_i) : '0;
  assign fire_o = |hits;

  always_comb begin
    logic found;
    found   = 1'b0;
    cause_o = '0;
    for (int k = 0; k < FLAG_W; k++) begin
      if (!found && hits[PRIO[k]]) begin
        cause_o[PRIO[k]] = 1'b1;
        found            = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpu_exc_default.sv
module fpu_exc_default
  import fpu_exc_pkg::*;
#(
  parameter int CC_W      = 4,
  parameter int UNORD_BIT = 0
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] enables_i,
  input  op_class_e         class_i,
  input  logic              sign_i,
  input  rmode_e            rmode_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CC_W-1:0]   cc_o
);

  logic [FLAG_W-1:0] masked;
  assign masked = flags_i & ~enables_i;

  always_comb begin
    data_o = result_i;
    cc_o   = cc_i;
    if (masked[F_INV]) begin
      case (class_i)
        CLS_ARITH: data_o = fp_qnan();
        CLS_CONV:  data_o = fp_max(sign_i);
        default:   cc_o[UNORD_BIT] = 1'b1;
      endcase
    end else if (masked[F_DZ]) begin
      data_o = fp_inf(sign_i);
    end else if (masked[F_OVF]) begin
      data_o = fp_ovf_default(sign_i, rmode_i);
    end else if (masked[F_UNF]) begin
      data_o = fp_zero(sign_i);
    end else if (masked[F_INX] || masked[F_DEN]) begin
      // rounded result, or operand already flushed by the datapath
      data_o = result_i;
    end
  end

endmodule

// File: rtl/fpu_exc_gate.sv
module fpu_exc_gate
  import fpu_exc_pkg::*;
#(
  parameter int CSR_W     = 32,
  parameter int ENA_LSB   = 12,
  parameter int RM_LSB    = 0,
  parameter int CC_W      = 4,
  parameter int UNORD_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic [CSR_W-1:0]  csr_rdata_o,
  input  logic              op_valid_i,
  input  logic [FLAG_W-1:0] op_flags_i,
  input  logic [1:0]        op_class_i,
  input  logic              op_sign_i,
  input  logic [DATA_W-1:0] op_result_i,
  input  logic [CC_W-1:0]   op_cc_i,
  output logic              trap_o,
  output logic [FLAG_W-1:0] trap_cause_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CC_W-1:0]   wr_cc_o
);

  // Internal events, named for the checker
  logic [FLAG_W-1:0] enables_w;
  rmode_e            rmode_w;
  logic              fire_w;
  logic [FLAG_W-1:0] cause_w;
  logic [DATA_W-1:0] subst_data_w;
  logic [CC_W-1:0]   subst_cc_w;

  fpu_exc_csr #(.CSR_W(CSR_W), .ENA_LSB(ENA_LSB), .RM_LSB(RM_LSB)) u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (csr_we_i),
    .wdata_i   (csr_wdata_i),
    .csr_o     (csr_rdata_o),
    .enables_o (enables_w),
    .rmode_o   (rmode_w)
  );

  fpu_exc_trap_sel u_sel (
    .valid_i   (op_valid_i),
    .flags_i   (op_flags_i),
    .enables_i (enables_w),
    .fire_o    (fire_w),
    .cause_o   (cause_w)
  );

  fpu_exc_default #(.CC_W(CC_W), .UNORD_BIT(UNORD_BIT)) u_def (
    .flags_i   (op_flags_i),
    .enables_i (enables_w),
    .class_i   (op_class_e'(op_class_i)),
    .sign_i    (op_sign_i),
    .rmode_i   (rmode_w),
    .result_i  (op_result_i),
    .cc_i      (op_cc_i),
    .data_o    (subst_data_w),
    .cc_o      (subst_cc_w)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      trap_o       <= 1'b0;
      trap_cause_o <= '0;
      wr_valid_o   <= 1'b0;
      wr_data_o    <= '0;
      wr_cc_o      <= '0;
    end else begin
      trap_o       <= fire_w;
      trap_cause_o <= cause_w;
      wr_valid_o   <= op_valid_i && !fire_w;
      if (op_valid_i && !fire_w) begin
        wr_data_o <= subst_data_w;
        wr_cc_o   <= subst_cc_w;
      end
    end
  end

endmodule

// File: rtl/fpu_exc_gate_chk.sv
module fpu_exc_gate_chk
  import fpu_exc_pkg::*;
#(
  parameter int CC_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [FLAG_W-1:0] op_flags_i,
  input logic [1:0]        op_class_i,
  input logic              trap_o,
  input logic [FLAG_W-1:0] trap_cause_o,
  input logic              wr_valid_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic [CC_W-1:0]   wr_cc_o,
  input logic [FLAG_W-1:0] enables_w,
  input logic              fire_w
);

  p_trap_needs_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(op_valid_i));

  p_trap_blocks_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !wr_valid_o);

  p_cause_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trap_cause_o) && (trap_o == (trap_cause_o != '0)));

  p_cause_enabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ((trap_cause_o & $past(op_flags_i & enables_w)) != '0));

  p_clean_op_writes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !fire_w) |=> wr_valid_o);

  p_cmp_unordered_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !fire_w && op_class_i == 2'b10 && op_flags_i[F_INV])
      |=> wr_cc_o[0]);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> (!wr_valid_o && !trap_o && $stable(wr_data_o) && $stable(wr_cc_o)));

  p_class_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |-> (op_class_i != 2'b11));

endmodule

bind fpu_exc_gate fpu_exc_gate_chk #(.CC_W(CC_W)) u_chk (.*);

// File: tb/fpu_exc_gate_test.sv
module fpu_exc_gate_test;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        csr_we_i;
  logic [31:0] csr_wdata_i;
  logic [31:0] csr_rdata_o;
  logic        op_valid_i;
  logic [5:0]  op_flags_i;
  logic [1:0]  op_class_i;
  logic        op_sign_i;
  logic [31:0] op_result_i;
  logic [3:0]  op_cc_i;
  logic        trap_o;
  logic [5:0]  trap_cause_o;
  logic        wr_valid_o;
  logic [31:0] wr_data_o;
  logic [3:0]  wr_cc_o;

  fpu_exc_gate uut (.*);

  always #4 clk_i = ~clk_i;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  // reference state
  logic [31:0] m_cr;
  logic        e_trap, e_wv;
  logic [5:0]  e_cause;
  logic [31:0] e_data;
  logic [3:0]  e_cc;
  string       e_tag;

  localparam logic [31:0] INF_P = 32'h7F800000;
  localparam logic [31:0] MAX_P = 32'h7F7FFFFF;
  localparam logic [31:0] QNAN  = 32'h7FC00000;

  function automatic logic [31:0] cr_word(input logic [5:0] en, input logic [1:0] rm);
    return {14'd0, en, 10'd0, rm};
  endfunction

  task automatic fail_line(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %h expected %h", e_tag, what, act, exp);
  endtask

  task automatic check_cycle();
    n_cmp++;
    if (trap_o !== e_trap)        fail_line("trap", 32'(trap_o), 32'(e_trap));
    if (trap_cause_o !== e_cause) fail_line("cause", 32'(trap_cause_o), 32'(e_cause));
    if (wr_valid_o !== e_wv)      fail_line("write", 32'(wr_valid_o), 32'(e_wv));
    if (wr_data_o !== e_data)     fail_line("data", wr_data_o, e_data);
    if (wr_cc_o !== e_cc)         fail_line("cc", 32'(wr_cc_o), 32'(e_cc));
    if (csr_rdata_o !== m_cr)     fail_line("csr R1", csr_rdata_o, m_cr);
  endtask

  task automatic step_idle(input bit noisy);
    @(negedge clk_i);
    check_cycle();
    csr_we_i   = 1'b0;
    op_valid_i = 1'b0;
    if (noisy) begin
      op_flags_i  = 6'h3F;
      op_result_i = $urandom;
      op_cc_i     = 4'hF;
    end
    e_trap = 0; e_cause = 0; e_wv = 0;
    e_tag  = "R12";
  endtask

  task automatic step_wr(input logic [31:0] v);
    @(negedge clk_i);
    check_cycle();
    op_valid_i  = 1'b0;
    csr_we_i    = 1'b1;
    csr_wdata_i = v;
    m_cr        = v;
    e_trap = 0; e_cause = 0; e_wv = 0;
    e_tag  = "R1";
  endtask

  task automatic step_op(input logic [5:0] fl, input logic [1:0] cls, input logic sg,
                         input logic [31:0] res, input logic [3:0] cc, input bit also_wr,
                         input logic [31:0] wv);
    logic [5:0] en, hits;
    logic [1:0] rm;
    int order [6] = '{0, 1, 5, 2, 3, 4};
    @(negedge clk_i);
    check_cycle();
    op_valid_i  = 1'b1;
    op_flags_i  = fl;
    op_class_i  = cls;
    op_sign_i   = sg;
    op_result_i = res;
    op_cc_i     = cc;
    csr_we_i    = also_wr;
    csr_wdata_i = wv;
    en   = m_cr[17:12];
    rm   = m_cr[1:0];
    hits = fl & en;
    if (hits != 0) begin
      e_trap = 1; e_wv = 0; e_cause = 0;
      e_tag = ($countones(hits) > 1) ? "R4" : "R3";
      for (int k = 0; k < 6; k++) begin
        if (e_cause == 0 && hits[order[k]]) e_cause[order[k]] = 1'b1;
      end
    end else begin
      e_trap = 0; e_cause = 0; e_wv = 1;
      e_data = res; e_cc = cc;
      if ($countones(fl[3:0]) > 1) e_tag = "R11";
      else if (fl[5]) e_tag = "R5";
      else e_tag = "R6";
      if (fl[0]) begin
        if ($countones(fl[3:0]) == 1) e_tag = "R10";
        if (cls == 2'b00) e_data = QNAN;
        else if (cls == 2'b01) e_data = {sg, MAX_P[30:0]};
        else e_cc = cc | 4'b0001;
      end else if (fl[1]) begin
        if ($countones(fl[3:0]) == 1) e_tag = "R9";
        e_data = {sg, INF_P[30:0]};
      end else if (fl[2]) begin
        if ($countones(fl[3:0]) == 1) e_tag = "R8";
        case (rm)
          2'b00: e_data = {sg, INF_P[30:0]};
          2'b01: e_data = {sg, MAX_P[30:0]};
          2'b10: e_data = sg ? {1'b1, MAX_P[30:0]} : INF_P;
          default: e_data = sg ? {1'b1, INF_P[30:0]} : MAX_P;
        endcase
      end else if (fl[3]) begin
        e_tag  = "R7";
        e_data = {sg, 31'd0};
      end
    end
    if (also_wr) m_cr = wv;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; csr_we_i = 0; csr_wdata_i = 0; op_valid_i = 0; op_flags_i = 0;
    op_class_i = 0; op_sign_i = 0; op_result_i = 0; op_cc_i = 0;
    m_cr = 0; e_trap = 0; e_cause = 0; e_wv = 0; e_data = 0; e_cc = 0; e_tag = "R2";
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    step_idle(0);                                   // R2 reset state checked here
    // R5/R6: all disabled, denormal and inexact pass the result
    step_op(6'b100000, 2'b00, 0, 32'h00400000, 4'h2, 0, 0);
    step_op(6'b010000, 2'b00, 1, 32'hC0490FDB, 4'h0, 0, 0);
    // R7 underflow -> signed zero
    step_op(6'b001000, 2'b00, 1, 32'h80000001, 4'h0, 0, 0);
    // R9 divide by zero
    step_op(6'b000010, 2'b00, 1, 32'h12345678, 4'h0, 0, 0);
    // R10 invalid per class
    step_op(6'b000001, 2'b00, 1, 32'h3F800000, 4'h0, 0, 0);
    step_op(6'b000001, 2'b01, 1, 32'h3F800000, 4'h0, 0, 0);
    step_op(6'b000001, 2'b10, 0, 32'h0000BEEF, 4'h4, 0, 0);
    // R8 overflow, each rounding mode and sign
    for (int m = 0; m < 4; m++) begin
      step_wr(cr_word(6'b000000, 2'(m)));
      step_op(6'b010100, 2'b00, 0, 32'h7F7FFFFF, 4'h0, 0, 0);
      step_op(6'b010100, 2'b00, 1, 32'hFF7FFFFF, 4'h0, 0, 0);
    end
    // R11 several masked
    step_op(6'b001110, 2'b00, 0, 32'h1, 4'h0, 0, 0);
    step_op(6'b001100, 2'b00, 1, 32'h1, 4'h0, 0, 0);
    // R12 idle with noise on inputs
    step_idle(1);
    step_idle(1);
    // R3 single enabled trap, then R4 priority
    step_wr(cr_word(6'b111111, 2'b00));
    step_op(6'b010000, 2'b00, 0, 32'h1, 4'h0, 0, 0);
    step_idle(0);
    step_op(6'b111100, 2'b00, 0, 32'h1, 4'h0, 0, 0);  // denormal beats overflow
    step_op(6'b111111, 2'b00, 0, 32'h1, 4'h0, 0, 0);  // invalid wins
    step_wr(cr_word(6'b001000, 2'b01));
    step_op(6'b001100, 2'b00, 1, 32'h5, 4'h0, 0, 0);  // underflow traps, overflow masked
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) step_idle(1);
      else if (r == 1) step_wr($urandom);
      else step_op(6'($urandom), 2'($urandom_range(0, 2)), 1'($urandom), $urandom,
                   4'($urandom), ($urandom_range(0, 7) == 0), $urandom);
    end
    step_idle(0);
    step_idle(0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule